// File: doc/BRIEF.md
# Clock Discipline Supervisor

This block is the supervisory sequencer of a timing slave that disciplines a local oscillator to a remote master. It steps through five phases: first acquiring time lock, then arming the one-pulse-per-second compare, then tracking. When sync messages stop arriving it holds the oscillator control word frozen. When messages come back it picks a recovery path from the size of the measured drift. The loop filter and the gain arithmetic lie outside the block. Its inputs are single-cycle strobes from that logic, a signed drift sample, and programmable thresholds.

Every state change is registered. `cmp_load_o` is a single-cycle request to load the pulse compare register with the next one-second boundary. `osc_hold_o` tells the oscillator control path to keep its current word. A timeout counter runs on a slow tick strobe while the block is arming or tracking, and it declares sync lost when no message has arrived for a programmable number of ticks.

Top module: `clk_disc_sup`

## Requirements
- R1: Synchronous active-high reset puts `state_o` at 0 (acquire) with `cmp_load_o` and `osc_hold_o` low, including when reset is applied mid-run.
- R2: State codes are 0 acquire, 1 pulse-arm, 2 tracking, 3 holdover, 4 recalibrate, and no other code appears. In acquire, `lock_i` moves the state to pulse-arm on the next clock, and every other strobe is ignored.
- R3: `cmp_load_o` is high for exactly one cycle: the first cycle in which `state_o` reads pulse-arm after entry from any other state.
- R4: In pulse-arm, `pulse_done_i` moves the state to tracking on the next clock.
- R5: In tracking, `sched_i` returns the state to pulse-arm so the next second's pulse gets scheduled.
- R6: In pulse-arm and tracking the loss counter adds one per `tick_i` and clears on `sync_arrive_i`. An arrival beats a tick in the same cycle. The counter is cleared in every other state. Once in tracking with the counter at least `loss_ticks_i`, the next clock enters holdover.
- R7: In tracking, sync loss takes priority over `sched_i` in the same cycle: the state goes to holdover and no compare load is issued.
- R8: `osc_hold_o` is high in exactly the cycles in which `state_o` is holdover. Holdover is left only on `sync_arrive_i`; ticks and other strobes do not move it.
- R9: On an arrival in holdover, when |`drift_i`| (two's complement) is below `near_lim_i` the state returns to tracking.
- R10: On an arrival in holdover, when |`drift_i`| is at least `near_lim_i` but below `far_lim_i` the state goes to recalibrate.
- R11: On an arrival in holdover, when |`drift_i`| is at least `far_lim_i` the state goes back to acquire. This includes the most negative drift value.
- R12: In recalibrate, `lock_i` moves the state to pulse-arm (with a compare load), and `pulse_done_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_i | input | 1 | Time-lock achieved strobe |
| pulse_done_i | input | 1 | Aligned pulse emitted strobe |
| sched_i | input | 1 | Schedule-next-second strobe while tracking |
| sync_arrive_i | input | 1 | Sync message arrival strobe |
| tick_i | input | 1 | Loss timeout tick strobe |
| drift_i | input | DW | Signed drift measured at arrival |
| near_lim_i | input | DW | Lower drift threshold (unsigned) |
| far_lim_i | input | DW | Upper drift threshold (unsigned) |
| loss_ticks_i | input | TW | Ticks without arrival that declare loss |
| state_o | output | 3 | Current supervisory state |
| cmp_load_o | output | 1 | Load next pulse compare request |
| osc_hold_o | output | 1 | Freeze oscillator control word |

## Verification
In tracking, sync loss and the schedule strobe can fall in the same cycle. The bench provokes this by holding `sched_i` high in the cycle right after the tick that brings the loss count to its limit. The next state must be holdover with `cmp_load_o` low. A second collision, an arrival together with a tick, is judged by counting how many further ticks are needed before holdover is entered: the merged tick must not count.

// File: rtl/cds_pkg.sv
package cds_pkg;
  typedef enum logic [2:0] {
    ST_ACQUIRE   = 3'd0,
    ST_PULSE_ARM = 3'd1,
    ST_TRACK     = 3'd2,
    ST_HOLD      = 3'd3,
    ST_RECAL     = 3'd4
  } cds_state_e;

  typedef enum logic [1:0] {
    DR_NEAR = 2'd0,
    DR_FAR  = 2'd1,
    DR_LOST = 2'd2
  } drift_cls_e;
endpackage

// File: rtl/cds_loss_timer.sv
module cds_loss_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_i,
  input  logic          arrive_i,
  input  logic          tick_i,
  input  logic [TW-1:0] limit_i,
  output logic          lost_o
);
  localparam logic [TW-1:0] CNT_MAX = '1;
  localparam logic [TW-1:0] CNT_ONE = {{(TW-1){1'b0}}, 1'b1};

  logic [TW-1:0] cnt_q;

  // arrival wins over a tick in the same cycle; count saturates
  always_ff @(posedge clk) begin
    if (rst || !run_i || arrive_i)
      cnt_q <= '0;
    else if (tick_i && (cnt_q != CNT_MAX))
      cnt_q <= cnt_q + CNT_ONE;
  end

  assign lost_o = run_i && (cnt_q >= limit_i);
endmodule

// File: rtl/cds_drift_class.sv
module cds_drift_class
  import cds_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] drift_i,
  input  logic [DW-1:0] near_lim_i,
  input  logic [DW-1:0] far_lim_i,
  output drift_cls_e    cls_o
);
  localparam logic [DW-1:0] MAG_ONE = {{(DW-1){1'b0}}, 1'b1};

  logic [DW-1:0] mag;

  // magnitude of a two's complement value; the most negative code maps to 2^(DW-1)
  always_comb begin
    mag = drift_i[DW-1] ? (~drift_i + MAG_ONE) : drift_i;
    if (mag >= far_lim_i)
      cls_o = DR_LOST;
    else if (mag >= near_lim_i)
      cls_o = DR_FAR;
    else
      cls_o = DR_NEAR;
  end
endmodule

// File: rtl/cds_seq_fsm.sv
module cds_seq_fsm
  import cds_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       lock_i,
  input  logic       pulse_i,
  input  logic       sched_i,
  input  logic       arrive_i,
  input  logic       lost_i,
  input  drift_cls_e cls_i,
  output logic [2:0] state_o,
  output logic       load_o,
  output logic       hold_o,
  output logic       run_o
);
  cds_state_e state_q, nxt;

  always_comb begin
    nxt = state_q;
    unique case (state_q)
      ST_ACQUIRE:   if (lock_i)  nxt = ST_PULSE_ARM;
      ST_PULSE_ARM: if (pulse_i) nxt = ST_TRACK;
      ST_TRACK: begin
        if (lost_i)       nxt = ST_HOLD;
        else if (sched_i) nxt = ST_PULSE_ARM;
      end
      ST_HOLD: begin
        if (arrive_i) begin
          unique case (cls_i)
            DR_NEAR: nxt = ST_TRACK;
            DR_FAR:  nxt = ST_RECAL;
            default: nxt = ST_ACQUIRE;
          endcase
        end
      end
      ST_RECAL:     if (lock_i)  nxt = ST_PULSE_ARM;
      default:      nxt = ST_ACQUIRE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_ACQUIRE;
      load_o  <= 1'b0;
      hold_o  <= 1'b0;
    end else begin
      state_q <= nxt;
      load_o  <= (nxt == ST_PULSE_ARM) && (state_q != ST_PULSE_ARM);
      hold_o  <= (nxt == ST_HOLD);
    end
  end

  assign state_o = state_q;
  assign run_o   = (state_q == ST_PULSE_ARM) || (state_q == ST_TRACK);
endmodule

// File: rtl/clk_disc_sup.sv
module clk_disc_sup
  import cds_pkg::*;
#(
  parameter int DW = 32,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lock_i,
  input  logic          pulse_done_i,
  input  logic          sched_i,
  input  logic          sync_arrive_i,
  input  logic          tick_i,
  input  logic [DW-1:0] drift_i,
  input  logic [DW-1:0] near_lim_i,
  input  logic [DW-1:0] far_lim_i,
  input  logic [TW-1:0] loss_ticks_i,
  output logic [2:0]    state_o,
  output logic          cmp_load_o,
  output logic          osc_hold_o
);
  logic       run;
  logic       lost;
  drift_cls_e cls;

  cds_loss_timer #(.TW(TW)) u_loss (
    .clk      (clk),
    .rst      (rst),
    .run_i    (run),
    .arrive_i (sync_arrive_i),
    .tick_i   (tick_i),
    .limit_i  (loss_ticks_i),
    .lost_o   (lost)
  );

  cds_drift_class #(.DW(DW)) u_drift (
    .drift_i    (drift_i),
    .near_lim_i (near_lim_i),
    .far_lim_i  (far_lim_i),
    .cls_o      (cls)
  );

  cds_seq_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .lock_i   (lock_i),
    .pulse_i  (pulse_done_i),
    .sched_i  (sched_i),
    .arrive_i (sync_arrive_i),
    .lost_i   (lost),
    .cls_i    (cls),
    .state_o  (state_o),
    .load_o   (cmp_load_o),
    .hold_o   (osc_hold_o),
    .run_o    (run)
  );
endmodule

// File: rtl/cds_sup_checker.sv
module cds_sup_checker (
  input logic       clk,
  input logic       rst,
  input logic       lock_i,
  input logic       pulse_done_i,
  input logic       sched_i,
  input logic       sync_arrive_i,
  input logic [2:0] state_o,
  input logic       cmp_load_o,
  input logic       osc_hold_o
);
  assert_legal_code_R2: assert property (@(posedge clk) disable iff (rst)
    state_o <= 3'd4);

  assert_acquire_exit_R2: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd0 && lock_i) |=> state_o == 3'd1);

  assert_load_on_entry_R3: assert property (@(posedge clk) disable iff (rst)
    cmp_load_o |-> (state_o == 3'd1 && $past(state_o) != 3'd1));

  assert_arm_exit_R4: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd1 && pulse_done_i) |=> state_o == 3'd2);

  assert_track_exit_R5: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd2 && sched_i) |=> (state_o == 3'd1 || state_o == 3'd3));

  assert_hold_from_track_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(osc_hold_o) |-> $past(state_o) == 3'd2);

  assert_hold_matches_R8: assert property (@(posedge clk) disable iff (rst)
    osc_hold_o == (state_o == 3'd3));

  assert_hold_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd3 && !sync_arrive_i) |=> state_o == 3'd3);

  assert_recal_exit_R12: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd4 && lock_i) |=> (state_o == 3'd1 && cmp_load_o));
endmodule

bind clk_disc_sup cds_sup_checker u_sup_chk (
  .clk           (clk),
  .rst           (rst),
  .lock_i        (lock_i),
  .pulse_done_i  (pulse_done_i),
  .sched_i       (sched_i),
  .sync_arrive_i (sync_arrive_i),
  .state_o       (state_o),
  .cmp_load_o    (cmp_load_o),
  .osc_hold_o    (osc_hold_o)
);

// File: tb/clk_disc_sup_bench.sv
`timescale 1ns/1ps
module clk_disc_sup_bench;
  localparam int DW = 8;
  localparam int TW = 8;
  localparam int NV = 29;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lock_i = 0, pulse_done_i = 0, sched_i = 0, sync_arrive_i = 0, tick_i = 0;
  logic [DW-1:0] drift_i = '0;
  logic [DW-1:0] near_lim_i = 8'd10;
  logic [DW-1:0] far_lim_i  = 8'd50;
  logic [TW-1:0] loss_ticks_i = 8'd3;
  logic [2:0] state_o;
  logic cmp_load_o, osc_hold_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  clk_disc_sup #(.DW(DW), .TW(TW)) u_clk_disc_sup (
    .clk(clk), .rst(rst), .lock_i(lock_i), .pulse_done_i(pulse_done_i),
    .sched_i(sched_i), .sync_arrive_i(sync_arrive_i), .tick_i(tick_i),
    .drift_i(drift_i), .near_lim_i(near_lim_i), .far_lim_i(far_lim_i),
    .loss_ticks_i(loss_ticks_i), .state_o(state_o), .cmp_load_o(cmp_load_o),
    .osc_hold_o(osc_hold_o)
  );

  // {lock,pulse,sched,arrive,tick} drift expect_state expect_load expect_hold req
  localparam logic [21:0] VEC [0:NV-1] = '{
    {5'b10000, 8'h00, 3'd1, 1'b1, 1'b0, 4'd2},  // R2 acquire -> arm, R3 load
    {5'b00000, 8'h00, 3'd1, 1'b0, 1'b0, 4'd3},  // R3 load lasts one cycle
    {5'b01000, 8'h00, 3'd2, 1'b0, 1'b0, 4'd4},  // R4
    {5'b00100, 8'h00, 3'd1, 1'b1, 1'b0, 4'd5},  // R5 next second
    {5'b01000, 8'h00, 3'd2, 1'b0, 1'b0, 4'd4},
    {5'b00001, 8'h00, 3'd2, 1'b0, 1'b0, 4'd6},  // R6 tick 1
    {5'b00010, 8'h00, 3'd2, 1'b0, 1'b0, 4'd6},  // R6 arrival clears
    {5'b00001, 8'h00, 3'd2, 1'b0, 1'b0, 4'd6},
    {5'b00001, 8'h00, 3'd2, 1'b0, 1'b0, 4'd6},
    {5'b00001, 8'h00, 3'd2, 1'b0, 1'b0, 4'd6},  // count reaches limit
    {5'b00000, 8'h00, 3'd3, 1'b0, 1'b1, 4'd6},  // R6 holdover
    {5'b00000, 8'h00, 3'd3, 1'b0, 1'b1, 4'd8},  // R8 stays
    {5'b01101, 8'h00, 3'd3, 1'b0, 1'b1, 4'd8},  // R8 other strobes ignored
    {5'b00010, 8'hFB, 3'd2, 1'b0, 1'b0, 4'd9},  // R9 drift -5
    {5'b00001, 8'h00, 3'd2, 1'b0, 1'b0, 4'd6},
    {5'b00001, 8'h00, 3'd2, 1'b0, 1'b0, 4'd6},
    {5'b00001, 8'h00, 3'd2, 1'b0, 1'b0, 4'd6},
    {5'b00000, 8'h00, 3'd3, 1'b0, 1'b1, 4'd6},
    {5'b00010, 8'h14, 3'd4, 1'b0, 1'b0, 4'd10}, // R10 drift +20
    {5'b01000, 8'h00, 3'd4, 1'b0, 1'b0, 4'd12}, // R12 pulse ignored
    {5'b10000, 8'h00, 3'd1, 1'b1, 1'b0, 4'd12}, // R12 relock
    {5'b01000, 8'h00, 3'd2, 1'b0, 1'b0, 4'd4},
    {5'b00001, 8'h00, 3'd2, 1'b0, 1'b0, 4'd6},
    {5'b00001, 8'h00, 3'd2, 1'b0, 1'b0, 4'd6},
    {5'b00001, 8'h00, 3'd2, 1'b0, 1'b0, 4'd6},
    {5'b00000, 8'h00, 3'd3, 1'b0, 1'b1, 4'd6},
    {5'b00010, 8'hCE, 3'd0, 1'b0, 1'b0, 4'd11}, // R11 drift -50
    {5'b01111, 8'h00, 3'd0, 1'b0, 1'b0, 4'd2},  // R2 others ignored
    {5'b10000, 8'h00, 3'd1, 1'b1, 1'b0, 4'd2}
  };

  task automatic expect_out(input int req, input logic [2:0] es, input logic el, input logic eh);
    checks++;
    if (state_o !== es || cmp_load_o !== el || osc_hold_o !== eh) begin
      errors++;
      $display("FAIL R%0d: state/load/hold actual %0d/%0b/%0b expected %0d/%0b/%0b",
               req, state_o, cmp_load_o, osc_hold_o, es, el, eh);
    end
  endtask

  task automatic step(input logic [4:0] s, input logic [7:0] d);
    {lock_i, pulse_done_i, sched_i, sync_arrive_i, tick_i} = s;
    drift_i = d;
    @(posedge clk);
    @(negedge clk);
    {lock_i, pulse_done_i, sched_i, sync_arrive_i, tick_i} = '0;
    drift_i = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expect_out(1, 3'd0, 1'b0, 1'b0);  // R1 reset state

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][21:17], VEC[i][16:9]);
      expect_out(int'(VEC[i][3:0]), VEC[i][8:6], VEC[i][5], VEC[i][4]);
    end

    // R7: loss and schedule in the same cycle
    step(5'b01000, 8'h00); expect_out(4, 3'd2, 1'b0, 1'b0);
    repeat (3) begin step(5'b00001, 8'h00); expect_out(7, 3'd2, 1'b0, 1'b0); end
    step(5'b00100, 8'h00); expect_out(7, 3'd3, 1'b0, 1'b1);

    // R10 boundary: drift equal to the lower threshold
    step(5'b00010, 8'd10); expect_out(10, 3'd4, 1'b0, 1'b0);
    step(5'b10000, 8'h00); expect_out(12, 3'd1, 1'b1, 1'b0);
    step(5'b01000, 8'h00); expect_out(4, 3'd2, 1'b0, 1'b0);

    // R6: arrival beats a merged tick
    step(5'b00001, 8'h00);
    step(5'b00001, 8'h00);
    step(5'b00011, 8'h00); expect_out(6, 3'd2, 1'b0, 1'b0);
    step(5'b00001, 8'h00);
    step(5'b00001, 8'h00);
    step(5'b00000, 8'h00); expect_out(6, 3'd2, 1'b0, 1'b0);
    step(5'b00001, 8'h00);
    step(5'b00000, 8'h00); expect_out(6, 3'd3, 1'b0, 1'b1);

    // R9 boundary: drift one below the lower threshold
    step(5'b00010, 8'd9); expect_out(9, 3'd2, 1'b0, 1'b0);

    // R11: most negative drift
    repeat (3) step(5'b00001, 8'h00);
    step(5'b00000, 8'h00); expect_out(6, 3'd3, 1'b0, 1'b1);
    step(5'b00010, 8'h80); expect_out(11, 3'd0, 1'b0, 1'b0);

    // R1: reset during holdover
    step(5'b10000, 8'h00);
    step(5'b01000, 8'h00);
    repeat (3) step(5'b00001, 8'h00);
    step(5'b00000, 8'h00); expect_out(8, 3'd3, 1'b0, 1'b1);
    rst = 1'b1;
    step(5'b00000, 8'h00);
    step(5'b00000, 8'h00);
    expect_out(1, 3'd0, 1'b0, 1'b0);
    rst = 1'b0;
    step(5'b00000, 8'h00); expect_out(1, 3'd0, 1'b0, 1'b0);

    finish_run();
  end
endmodule